// File: doc/BRIEF.md
# Dual-Read Multiply-Accumulate Execution Unit

This unit is the execute stage for a family of one-word, one-cycle signal-processing instructions. Each instruction joins an arithmetic step on two fractional accumulators (multiply, multiply-accumulate, either of them with optional rounding, add, subtract, or no arithmetic at all) with two data-memory reads issued in the same cycle. The first read takes its address from pointer R0 or R1 and loads input register Y0 or Y1. The second read always takes its address from R3 and loads X0. Both pointers are post-modified in that same cycle.

Data words are signed 16-bit fractions. Accumulators are 36 bits wide, made of 4 guard bits, a 16-bit upper word and a 16-bit lower word. Products are shifted left by one bit so that the binary point is aligned. The arithmetic always reads the input registers as they stood before the cycle's loads, so a loaded word is first used by the next instruction. A separate load port sets the input, pointer and offset registers before a run.

The instruction arrives on a valid/ready handshake. The memory controls back-pressure through `mem_ready`, and `in_ready` follows it. While `in_ready` is low, the producer must hold the instruction fields stable. An instruction executes, and the read data is sampled, on the clock edge where `in_valid` and `mem_ready` are both high.

Top module: `dualrd_mac_unit`

## Requirements
- R1: MPY (op=3) writes the product of the pair chosen by `sel` (0: Y1·X0, 1: Y1·Y0, 2: Y0·X0, 3: zero) into the accumulator chosen by `dst`. The product is the signed 16x16 result, sign-extended to 36 bits and shifted left by one; 0x8000·0x8000 gives 0x0_8000_0000.
- R2: MAC (op=4) adds that same product to the selected accumulator, modulo 2^36.
- R3: MPYR (op=5) and MACR (op=6) form the same result as MPY and MAC, add 0x8000, and then clear bits 15:0.
- R4: ADD (op=1) and SUB (op=2) add the source word to, or subtract it from, the selected accumulator. The source is chosen by `sel` (0: X0, 1: Y1, 2: Y0, 3: zero) and is placed at bits 31:16 with sign extension.
- R5: `dst` 0 selects acc0 and `dst` 1 selects acc1. The other accumulator is unchanged. MOVE (op=0) and op=7 leave both accumulators unchanged.
- R6: Arithmetic operands are the register values before the current instruction's loads.
- R7: The first read address is R0 (`rd1_ptr`=0) or R1 (`rd1_ptr`=1). `rd1_data` loads Y0 (`rd1_dst`=0) or Y1 (`rd1_dst`=1). The pointer then advances by 1 (`rd1_step_n`=0) or by N (`rd1_step_n`=1), modulo 2^16.
- R8: The second read address is R3 and `rd2_data` loads X0. R3 then moves by +1 (`rd2_down`=0) or by -1 (`rd2_down`=1), modulo 2^16.
- R9: `in_ready` equals `mem_ready`. With `in_valid` and `mem_ready` not both high, no accumulator, input register or pointer changes, apart from a write through the load port.
- R10: When `ld_en` is high, `ld_data` is written to the register coded by `ld_sel` (0 X0, 1 Y0, 2 Y1, 3 R0, 4 R1, 5 R3, 6 N). This write takes priority over an instruction's update of the same register.
- R11: After reset, all accumulators, input registers and pointers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle (equals mem_ready) |
| op | input | 3 | Arithmetic code |
| sel | input | 2 | Operand pair or source select |
| dst | input | 1 | Target accumulator |
| rd1_ptr | input | 1 | First read pointer: R0 or R1 |
| rd1_dst | input | 1 | First read target: Y0 or Y1 |
| rd1_step_n | input | 1 | First pointer step: 1 or N |
| rd2_down | input | 1 | R3 step direction |
| mem_ready | input | 1 | Memory returns both words this cycle |
| rd_req | output | 1 | Read request for both ports |
| rd1_addr | output | 16 | First read address |
| rd1_data | input | 16 | First read word |
| rd2_addr | output | 16 | Second read address |
| rd2_data | input | 16 | Second read word |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register load target |
| ld_data | input | 16 | Register load value |
| acc0 | output | 36 | Accumulator 0 |
| acc1 | output | 36 | Accumulator 1 |
| x0 | output | 16 | Input register X0 |
| y0 | output | 16 | Input register Y0 |
| y1 | output | 16 | Input register Y1 |
| r0 | output | 16 | Pointer R0 |
| r1 | output | 16 | Pointer R1 |
| r3 | output | 16 | Pointer R3 |

## Verification
A wrong pointer shows up at once on `rd1_addr` or `rd2_addr` during the next instruction. A wrong load or operand choice stays hidden until the next arithmetic instruction that reads that register, usually one or two instructions later. The bench therefore checks the input registers and pointers directly after every instruction, and the accumulators after every instruction as well. A rounding or guard-bit error appears only in particular low or top bits, so the corner vectors target exact half-LSB and full-scale products.

// File: rtl/dualrd_mac_pkg.sv
package dualrd_mac_pkg;
  typedef enum logic [2:0] {
    OP_MOVE = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_MPY = 3'd3,
    OP_MAC  = 3'd4, OP_MPYR = 3'd5, OP_MACR = 3'd6, OP_NOP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    LD_X0 = 3'd0, LD_Y0 = 3'd1, LD_Y1 = 3'd2, LD_R0 = 3'd3,
    LD_R1 = 3'd4, LD_R3 = 3'd5, LD_N = 3'd6, LD_NONE = 3'd7
  } ld_e;
endpackage

// File: rtl/dualrd_mac_agu.sv
module dualrd_mac_agu #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] r0,
  input  logic [AW-1:0] r1,
  input  logic [AW-1:0] r3,
  input  logic [AW-1:0] nreg,
  input  logic          ptr_sel,
  input  logic          step_n,
  input  logic          down,
  output logic [AW-1:0] addr1,
  output logic [AW-1:0] addr2,
  output logic [AW-1:0] ptr_next,
  output logic [AW-1:0] r3_next
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    addr1    = ptr_sel ? r1 : r0;
    addr2    = r3;
    ptr_next = addr1 + (step_n ? nreg : ONE);
    r3_next  = down ? (r3 - ONE) : (r3 + ONE);
  end
endmodule

// File: rtl/dualrd_mac_alu.sv
module dualrd_mac_alu
  import dualrd_mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  localparam int ACW  = 2*DW + GUARD
) (
  input  op_e            op,
  input  logic [1:0]     sel,
  input  logic           dst,
  input  logic [DW-1:0]  x0,
  input  logic [DW-1:0]  y0,
  input  logic [DW-1:0]  y1,
  input  logic [ACW-1:0] acc0,
  input  logic [ACW-1:0] acc1,
  output logic [ACW-1:0] res,
  output logic           we
);
  localparam logic [ACW-1:0] HALF = ACW'(1) << (DW-1);
  localparam logic [ACW-1:0] MASK = ~((ACW'(1) << DW) - ACW'(1));

  logic [DW-1:0]          ma, mb, src;
  logic signed [2*DW-1:0] ea, eb, prod;
  logic [ACW-1:0]         prodx, srcx, base, sum;

  always_comb begin
    unique case (sel)
      2'd0:    begin ma = y1; mb = x0; src = x0; end
      2'd1:    begin ma = y1; mb = y0; src = y1; end
      2'd2:    begin ma = y0; mb = x0; src = y0; end
      default: begin ma = '0; mb = '0; src = '0; end
    endcase
  end

  always_comb begin
    ea    = {{DW{ma[DW-1]}}, ma};
    eb    = {{DW{mb[DW-1]}}, mb};
    prod  = ea * eb;
    prodx = {{GUARD{prod[2*DW-1]}}, prod} << 1;
    srcx  = {{GUARD{src[DW-1]}}, src, {DW{1'b0}}};
    base  = dst ? acc1 : acc0;
    unique case (op)
      OP_MPY, OP_MPYR: sum = prodx;
      OP_MAC, OP_MACR: sum = base + prodx;
      OP_ADD:          sum = base + srcx;
      OP_SUB:          sum = base - srcx;
      default:         sum = base;
    endcase
    res = (op == OP_MPYR || op == OP_MACR) ? ((sum + HALF) & MASK) : sum;
    we  = (op != OP_MOVE) && (op != OP_NOP);
  end
endmodule

// File: rtl/dualrd_mac_unit.sv
module dualrd_mac_unit
  import dualrd_mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int GUARD = 4,
  localparam int ACW  = 2*DW + GUARD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     op,
  input  logic [1:0]     sel,
  input  logic           dst,
  input  logic           rd1_ptr,
  input  logic           rd1_dst,
  input  logic           rd1_step_n,
  input  logic           rd2_down,
  input  logic           mem_ready,
  output logic           rd_req,
  output logic [AW-1:0]  rd1_addr,
  input  logic [DW-1:0]  rd1_data,
  output logic [AW-1:0]  rd2_addr,
  input  logic [DW-1:0]  rd2_data,
  input  logic           ld_en,
  input  logic [2:0]     ld_sel,
  input  logic [DW-1:0]  ld_data,
  output logic [ACW-1:0] acc0,
  output logic [ACW-1:0] acc1,
  output logic [DW-1:0]  x0,
  output logic [DW-1:0]  y0,
  output logic [DW-1:0]  y1,
  output logic [AW-1:0]  r0,
  output logic [AW-1:0]  r1,
  output logic [AW-1:0]  r3
);
  logic           fire;
  logic [AW-1:0]  nreg, ptr_next, r3_next, ld_addr;
  logic [ACW-1:0] alu_res;
  logic           alu_we;
  logic [ACW-1:0] acc_q [2];

  assign fire     = in_valid && mem_ready;
  assign in_ready = mem_ready;
  assign rd_req   = in_valid;
  assign ld_addr  = ld_data[AW-1:0];

  function automatic logic ld_hit(input logic en, input logic [2:0] s, input ld_e which);
    return en && (ld_e'(s) == which);
  endfunction

  dualrd_mac_agu #(.AW(AW)) u_agu (
    .r0(r0), .r1(r1), .r3(r3), .nreg(nreg),
    .ptr_sel(rd1_ptr), .step_n(rd1_step_n), .down(rd2_down),
    .addr1(rd1_addr), .addr2(rd2_addr),
    .ptr_next(ptr_next), .r3_next(r3_next)
  );

  dualrd_mac_alu #(.DW(DW), .GUARD(GUARD)) u_alu (
    .op(op_e'(op)), .sel(sel), .dst(dst),
    .x0(x0), .y0(y0), .y1(y1),
    .acc0(acc_q[0]), .acc1(acc_q[1]),
    .res(alu_res), .we(alu_we)
  );

  // Input registers: load port first, then the cycle's memory words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x0 <= '0; y0 <= '0; y1 <= '0;
    end else begin
      if (ld_hit(ld_en, ld_sel, LD_X0))      x0 <= ld_data;
      else if (fire)                         x0 <= rd2_data;
      if (ld_hit(ld_en, ld_sel, LD_Y0))      y0 <= ld_data;
      else if (fire && !rd1_dst)             y0 <= rd1_data;
      if (ld_hit(ld_en, ld_sel, LD_Y1))      y1 <= ld_data;
      else if (fire && rd1_dst)              y1 <= rd1_data;
    end
  end

  // Pointers and offset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0 <= '0; r1 <= '0; r3 <= '0; nreg <= '0;
    end else begin
      if (ld_hit(ld_en, ld_sel, LD_R0))      r0 <= ld_addr;
      else if (fire && !rd1_ptr)             r0 <= ptr_next;
      if (ld_hit(ld_en, ld_sel, LD_R1))      r1 <= ld_addr;
      else if (fire && rd1_ptr)              r1 <= ptr_next;
      if (ld_hit(ld_en, ld_sel, LD_R3))      r3 <= ld_addr;
      else if (fire)                         r3 <= r3_next;
      if (ld_hit(ld_en, ld_sel, LD_N))       nreg <= ld_addr;
    end
  end

  // Accumulators
  for (genvar g = 0; g < 2; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n)                                   acc_q[g] <= '0;
      else if (fire && alu_we && (dst == 1'(g)))    acc_q[g] <= alu_res;
    end
  end

  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];
endmodule

// File: rtl/dualrd_mac_unit_chk.sv
module dualrd_mac_unit_chk #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int GUARD = 4,
  localparam int ACW  = 2*DW + GUARD
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           mem_ready,
  input logic [2:0]     op,
  input logic           dst,
  input logic           rd2_down,
  input logic [DW-1:0]  rd2_data,
  input logic           ld_en,
  input logic [2:0]     ld_sel,
  input logic [ACW-1:0] acc0,
  input logic [ACW-1:0] acc1,
  input logic [DW-1:0]  x0,
  input logic [AW-1:0]  r3
);
  logic fire;
  assign fire = in_valid && mem_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !ld_en) |=> ($stable(acc0) && $stable(acc1) && $stable(r3) && $stable(x0))); // R9

  AST_MOVE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == 3'd0 || op == 3'd7)) |=> ($stable(acc0) && $stable(acc1))); // R5

  AST_OTHER_ACC1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dst) |=> $stable(acc1)); // R5

  AST_OTHER_ACC0: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dst) |=> $stable(acc0)); // R5

  AST_ROUND_LOW0: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dst && (op == 3'd5 || op == 3'd6)) |=> (acc0[DW-1:0] == '0)); // R3

  AST_ROUND_LOW1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dst && (op == 3'd5 || op == 3'd6)) |=> (acc1[DW-1:0] == '0)); // R3

  AST_X0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(ld_en && ld_sel == 3'd0)) |=> (x0 == $past(rd2_data))); // R8

  AST_R3_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(ld_en && ld_sel == 3'd5)) |=>
      (r3 == ($past(rd2_down) ? ($past(r3) - AW'(1)) : ($past(r3) + AW'(1))))); // R8
endmodule

bind dualrd_mac_unit dualrd_mac_unit_chk #(.DW(DW), .AW(AW), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mem_ready(mem_ready),
  .op(op), .dst(dst), .rd2_down(rd2_down), .rd2_data(rd2_data),
  .ld_en(ld_en), .ld_sel(ld_sel), .acc0(acc0), .acc1(acc1), .x0(x0), .r3(r3)
);

// File: tb/dualrd_mac_unit_bench.sv
module dualrd_mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, mem_ready, rd_req;
  logic [2:0]  op;
  logic [1:0]  sel;
  logic        dst, rd1_ptr, rd1_dst, rd1_step_n, rd2_down;
  logic [15:0] rd1_addr, rd2_addr, rd1_data, rd2_data;
  logic        ld_en;
  logic [2:0]  ld_sel;
  logic [15:0] ld_data;
  logic [35:0] acc0, acc1;
  logic [15:0] x0, y0, y1, r0, r1, r3;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dualrd_mac_unit u_dualrd_mac_unit (.*);

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sel;
    logic        dst, p1, d1, m1, m2;
    logic [15:0] d1v, d2v;
    logic [35:0] ea0, ea1;
    logic [15:0] er0, er1, er3;
  } vec_t;

  // Starting point: X0=4000 Y0=2000 Y1=C000 R0=10 R1=20 R3=30 N=4
  localparam vec_t VECS [9] = '{
    '{3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h4000, 36'h0_1000_0000, 36'h0,            16'h11, 16'h20, 16'h31},
    '{3'd4, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h7FFF, 16'h8000, 36'hF_F000_0000, 36'h0,            16'h11, 16'h24, 16'h30},
    '{3'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0001, 16'h4000, 36'hF_F000_0000, 36'hF_8001_0000, 16'h15, 16'h24, 16'h31},
    '{3'd5, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0003, 16'h8000, 36'hF_F000_0000, 36'h0_0001_0000, 16'h15, 16'h25, 16'h30},
    '{3'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h8000, 36'hF_EFFD_0000, 36'h0_0001_0000, 16'h16, 16'h25, 16'h31},
    '{3'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0001, 16'h8000, 36'hF_EFFD_0000, 36'h0_0004_0000, 16'h16, 16'h29, 16'h30},
    '{3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h8000, 36'hF_EFFD_0000, 36'h0_8004_0000, 16'h17, 16'h29, 16'h31},
    '{3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h4000, 16'h5678, 36'hF_EFFD_0000, 36'h0_8004_0000, 16'h17, 16'h2A, 16'h30},
    '{3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0002, 16'h0000, 36'h0_0001_0000, 36'h0_8004_0000, 16'h18, 16'h2A, 16'h31}
  };

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_data = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic issue(input logic [2:0] o, input logic [1:0] s, input logic ds,
                       input logic p1, input logic d1, input logic m1, input logic m2,
                       input logic [15:0] d1v, input logic [15:0] d2v, input logic rdy);
    @(negedge clk);
    op = o; sel = s; dst = ds; rd1_ptr = p1; rd1_dst = d1; rd1_step_n = m1; rd2_down = m2;
    rd1_data = d1v; rd2_data = d2v; in_valid = 1'b1; mem_ready = rdy;
  endtask

  task automatic finish_issue();
    @(posedge clk); #1;
    in_valid = 1'b0; mem_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] cr0, cr1, cr3;
    rst_n = 1'b0; in_valid = 1'b0; mem_ready = 1'b0; op = '0; sel = '0; dst = 1'b0;
    rd1_ptr = 1'b0; rd1_dst = 1'b0; rd1_step_n = 1'b0; rd2_down = 1'b0;
    rd1_data = '0; rd2_data = '0; ld_en = 1'b0; ld_sel = '0; ld_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check(acc0 == 0 && acc1 == 0, "R11 acc reset", {acc0[17:0], acc1[17:0]}, 36'h0);
    check(x0 == 0 && y0 == 0 && y1 == 0, "R11 input reset", {x0, y0}, 36'h0);
    check(r0 == 0 && r1 == 0 && r3 == 0, "R11 pointer reset", {r0, r3}, 36'h0);
    @(negedge clk); rst_n = 1'b1;

    load(3'd0, 16'h4000); load(3'd1, 16'h2000); load(3'd2, 16'hC000);
    load(3'd3, 16'h0010); load(3'd4, 16'h0020); load(3'd5, 16'h0030); load(3'd6, 16'h0004);
    check(x0 == 16'h4000 && y1 == 16'hC000 && r3 == 16'h0030, "R10 load port", {x0, y1}, {16'h4000, 16'hC000});

    cr0 = 16'h10; cr1 = 16'h20; cr3 = 16'h30;
    // R1 R2 R3 R4 R5 R6 R7 R8: walked vector table
    foreach (VECS[i]) begin
      issue(VECS[i].op, VECS[i].sel, VECS[i].dst, VECS[i].p1, VECS[i].d1, VECS[i].m1, VECS[i].m2,
            VECS[i].d1v, VECS[i].d2v, 1'b1);
      #1;
      check(rd1_addr == (VECS[i].p1 ? cr1 : cr0), $sformatf("R7 addr1 v%0d", i), rd1_addr, VECS[i].p1 ? cr1 : cr0);
      check(rd2_addr == cr3, $sformatf("R8 addr2 v%0d", i), rd2_addr, cr3);
      check(in_ready == 1'b1 && rd_req == 1'b1, $sformatf("R9 handshake v%0d", i), {in_ready, rd_req}, 2'b11);
      finish_issue();
      check(acc0 == VECS[i].ea0, $sformatf("R1-R6 acc0 v%0d", i), acc0, VECS[i].ea0);
      check(acc1 == VECS[i].ea1, $sformatf("R1-R6 acc1 v%0d", i), acc1, VECS[i].ea1);
      check(r0 == VECS[i].er0 && r1 == VECS[i].er1, $sformatf("R7 ptr v%0d", i), {r0, r1}, {VECS[i].er0, VECS[i].er1});
      check(r3 == VECS[i].er3, $sformatf("R8 r3 v%0d", i), r3, VECS[i].er3);
      check(x0 == VECS[i].d2v, $sformatf("R8 x0 load v%0d", i), x0, VECS[i].d2v);
      check((VECS[i].d1 ? y1 : y0) == VECS[i].d1v, $sformatf("R7 y load v%0d", i), VECS[i].d1 ? y1 : y0, VECS[i].d1v);
      cr0 = VECS[i].er0; cr1 = VECS[i].er1; cr3 = VECS[i].er3;
    end

    // R9: stalled instruction changes nothing
    issue(3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7777, 16'h7777, 1'b0);
    #1;
    check(in_ready == 1'b0, "R9 in_ready low", in_ready, 1'b0);
    finish_issue();
    check(acc0 == 36'h0_0001_0000 && r3 == 16'h31 && x0 == 16'h0000 && r0 == 16'h18,
          "R9 stall hold", {acc0[19:0], r3}, {20'h1_0000, 16'h31});

    // R10: load port beats the memory word for X0
    issue(3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0005, 16'h2222, 1'b1);
    ld_en = 1'b1; ld_sel = 3'd0; ld_data = 16'h1111;
    finish_issue();
    ld_en = 1'b0;
    check(x0 == 16'h1111, "R10 load priority", x0, 16'h1111);
    check(r3 == 16'h32, "R10 r3 still steps", r3, 16'h32);

    // R1: full-scale negative times negative lands in guard bits
    load(3'd0, 16'h8000); load(3'd1, 16'h8000);
    issue(3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1);
    finish_issue();
    check(acc0 == 36'h0_8000_0000, "R1 full-scale product", acc0, 36'h0_8000_0000);

    // R7 R8 wrap, R1 zero pair on acc1
    load(3'd5, 16'h0000); load(3'd4, 16'hFFFE);
    issue(3'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0009, 16'h0008, 1'b1);
    finish_issue();
    check(r3 == 16'hFFFF, "R8 r3 wrap down", r3, 16'hFFFF);
    check(r1 == 16'h0002, "R7 r1 wrap by N", r1, 16'h0002);
    check(acc1 == 36'h0, "R1 sel3 zero product", acc1, 36'h0);
    check(acc0 == 36'h0_8000_0000, "R5 other acc kept", acc0, 36'h0_8000_0000);

    // R5: op 7 leaves accumulators alone
    issue(3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0001, 1'b1);
    finish_issue();
    check(acc0 == 36'h0_8000_0000 && acc1 == 36'h0, "R5 op7 no arithmetic", acc0, 36'h0_8000_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule